// File: doc/BRIEF.md
# Hot-Plug I/O Expander Bridge

This block carries the hot-plug signals of three downstream ports through an external I/O expander on a two-wire management bus, so the device spends no pins on them. It keeps one shadow of the output image that the expander last accepted and one shadow of the input image it last returned. When the requested outputs differ from the accepted image, the block asks a separate byte-level bus master engine to write the whole output image. When the expander pulls its active-low interrupt line, the block asks the engine to read the whole input image.

The engine is driven through a level request and a one-cycle acknowledge that carries an error flag. The error flag covers both a NACK and lost arbitration. Only one command is outstanding at a time. A failed command is reissued unchanged. Output changes that arrive during a write are merged into one follow-up write. An interrupt seen during a write is queued and served before that follow-up write. The expander's 7-bit address and its two register offsets are configuration inputs.

Top module: `hpx_bridge`

## Requirements
- R1: While `cfg_done_i` is low, `cmd_req_o` stays low, whatever the outputs and the interrupt line do.
- R2: After reset the accepted output image is 0. When `hp_out_i` differs from the accepted image and the block is idle, `cmd_req_o` rises on the next cycle with `cmd_kind_o` = 0 (write). The command carries `cmd_wdata_o` equal to the whole of `hp_out_i`, `cmd_reg_o` = `out_reg_i` and `cmd_addr_o` = `exp_addr_i`. An image equal to the accepted one issues no command.
- R3: `exp_int_ni` passes through a two-flop synchronizer. A low level driven just after a clock edge makes `cmd_req_o` rise after the third following edge, with `cmd_kind_o` = 1 (read) and `cmd_reg_o` = `in_reg_i`. The read repeats for as long as the line is still low when the block returns to idle.
- R4: `cmd_req_o` and its command fields hold steady until `cmd_ack_i`. In the cycle after the acknowledge, `cmd_req_o` is low.
- R5: An acknowledge with `cmd_err_i` high is followed by one cycle with the request low. The same command, with the same kind and the same write data, is then reissued.
- R6: If `hp_out_i` changes while a write is in flight, exactly one further write follows its success, carrying the latest image. Intermediate images are never sent.
- R7: An interrupt level seen while a write is in flight queues a read. That read is issued right after the write succeeds, before any further write.
- R8: On a successful read, `hp_in_o` takes `cmd_rdata_i`. For one cycle, `in_chg_o[p]` pulses for each port p whose field `[4p+3:4p]` changed. Indices 0, 1 and 2 stand for downstream ports 2, 4 and 6.
- R9: During reset `cmd_req_o`, `hp_in_o` and `in_chg_o` are all zero.
- R10: A read acknowledged with an error leaves `hp_in_o` unchanged and raises no change strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_done_i | input | 1 | Reset-time configuration finished |
| exp_addr_i | input | 7 | Expander bus address |
| out_reg_i | input | 8 | Expander output register offset |
| in_reg_i | input | 8 | Expander input register offset |
| hp_out_i | input | 12 | Requested hot-plug output image, 4 bits per port |
| exp_int_ni | input | 1 | Expander interrupt, active low, asynchronous |
| cmd_req_o | output | 1 | Command request to the bus engine |
| cmd_kind_o | output | 1 | 0 = write image, 1 = offset write then repeated-start read |
| cmd_addr_o | output | 7 | Target address |
| cmd_reg_o | output | 8 | Register offset for this command |
| cmd_wdata_o | output | 12 | Output image to write |
| cmd_ack_i | input | 1 | Command finished (one cycle) |
| cmd_err_i | input | 1 | With ack: NACK or arbitration lost |
| cmd_rdata_i | input | 12 | Input image returned by a read, valid with ack |
| hp_in_o | output | 12 | Input shadow image |
| in_chg_o | output | 3 | Per-port input change strobe |

## Verification
The bench targets the overlap cases. These are an interrupt arriving during a write, outputs changing during a write or during a retry, and a failed read. A design that served the queued read after the follow-up write, or dropped it, would show a write where a read is due. A design that retried with the newest image would break the retry-same-data check. A design that updated the shadow on an errored read would flag spurious port changes. The level-sensitive repeat is checked by holding the interrupt low across a read completion, and a design that treated the interrupt as an edge would not issue the second read.

// File: rtl/hpx_pkg.sv
package hpx_pkg;
  typedef enum logic {CMD_WRITE = 1'b0, CMD_READ = 1'b1} cmd_kind_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_BUSY = 2'd1, ST_GAP = 2'd2} seq_st_e;
endpackage

// File: rtl/hpx_sync.sv
module hpx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_ni,
  output logic lvl_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= '1;
        else         ff_q <= async_ni;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= '1;
        else         ff_q <= {ff_q[STAGES-2:0], async_ni};
    end
  endgenerate

  // internal level is active high
  assign lvl_o = ~ff_q[STAGES-1];
endmodule

// File: rtl/hpx_seq.sv
module hpx_seq
  import hpx_pkg::*;
#(
  parameter int OUT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_done_i,
  input  logic [OUT_W-1:0] hp_out_i,
  input  logic             int_lvl_i,
  input  logic             ack_i,
  input  logic             err_i,
  output logic             req_o,
  output cmd_kind_e        kind_o,
  output logic [OUT_W-1:0] wdata_o,
  output logic             rd_ok_o
);
  seq_st_e          state_q;
  cmd_kind_e        kind_q;
  logic [OUT_W-1:0] wr_img_q;
  logic [OUT_W-1:0] acc_img_q;
  logic             int_pend_q;
  logic             dirty;

  assign dirty = (hp_out_i != acc_img_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      kind_q     <= CMD_WRITE;
      wr_img_q   <= '0;
      acc_img_q  <= '0;
      int_pend_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (cfg_done_i) begin
            if (int_pend_q || (!dirty && int_lvl_i)) begin
              state_q    <= ST_BUSY;
              kind_q     <= CMD_READ;
              int_pend_q <= 1'b0;
            end else if (dirty) begin
              state_q  <= ST_BUSY;
              kind_q   <= CMD_WRITE;
              wr_img_q <= hp_out_i;
            end
          end
        end
        ST_BUSY: begin
          if (ack_i) begin
            state_q <= err_i ? ST_GAP : ST_IDLE;
            if (!err_i && kind_q == CMD_WRITE) acc_img_q <= wr_img_q;
          end
          if (kind_q == CMD_WRITE && int_lvl_i) int_pend_q <= 1'b1;
        end
        ST_GAP: begin
          state_q <= ST_BUSY;  // reissue same command
          if (kind_q == CMD_WRITE && int_lvl_i) int_pend_q <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_o   = (state_q == ST_BUSY);
  assign kind_o  = kind_q;
  assign wdata_o = wr_img_q;
  assign rd_ok_o = req_o && ack_i && !err_i && (kind_q == CMD_READ);

  AST_GAP_REISSUES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GAP) |=> (req_o && $stable(kind_q) && $stable(wr_img_q))); // R5
  AST_ACC_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(acc_img_q) |-> $past(req_o && ack_i && !err_i && kind_q == CMD_WRITE)); // R2
  AST_STATE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != 2'd3); // R4
endmodule

// File: rtl/hpx_in_shadow.sv
module hpx_in_shadow #(
  parameter int NUM_PORTS   = 3,
  parameter int IN_PER_PORT = 4,
  localparam int IN_W       = NUM_PORTS * IN_PER_PORT
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 upd_i,
  input  logic [IN_W-1:0]      rdata_i,
  output logic [IN_W-1:0]      shadow_o,
  output logic [NUM_PORTS-1:0] chg_o
);
  logic [NUM_PORTS-1:0] diff;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign diff[p] = |(rdata_i[p*IN_PER_PORT +: IN_PER_PORT] ^
                       shadow_o[p*IN_PER_PORT +: IN_PER_PORT]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_o <= '0;
      chg_o    <= '0;
    end else begin
      chg_o <= upd_i ? diff : '0;
      if (upd_i) shadow_o <= rdata_i;
    end
  end

  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(shadow_o)); // R10
endmodule

// File: rtl/hpx_bridge.sv
module hpx_bridge
  import hpx_pkg::*;
#(
  parameter int NUM_PORTS    = 3,
  parameter int OUT_PER_PORT = 4,
  parameter int IN_PER_PORT  = 4,
  parameter int SYNC_STAGES  = 2,
  localparam int OUT_W       = NUM_PORTS * OUT_PER_PORT,
  localparam int IN_W        = NUM_PORTS * IN_PER_PORT
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_done_i,
  input  logic [6:0]           exp_addr_i,
  input  logic [7:0]           out_reg_i,
  input  logic [7:0]           in_reg_i,
  input  logic [OUT_W-1:0]     hp_out_i,
  input  logic                 exp_int_ni,
  output logic                 cmd_req_o,
  output logic                 cmd_kind_o,
  output logic [6:0]           cmd_addr_o,
  output logic [7:0]           cmd_reg_o,
  output logic [OUT_W-1:0]     cmd_wdata_o,
  input  logic                 cmd_ack_i,
  input  logic                 cmd_err_i,
  input  logic [IN_W-1:0]      cmd_rdata_i,
  output logic [IN_W-1:0]      hp_in_o,
  output logic [NUM_PORTS-1:0] in_chg_o
);
  logic      int_lvl;
  logic      rd_ok;
  cmd_kind_e kind;

  hpx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_ni(exp_int_ni), .lvl_o(int_lvl)
  );

  hpx_seq #(.OUT_W(OUT_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_done_i(cfg_done_i),
    .hp_out_i(hp_out_i), .int_lvl_i(int_lvl),
    .ack_i(cmd_ack_i), .err_i(cmd_err_i),
    .req_o(cmd_req_o), .kind_o(kind), .wdata_o(cmd_wdata_o), .rd_ok_o(rd_ok)
  );

  hpx_in_shadow #(.NUM_PORTS(NUM_PORTS), .IN_PER_PORT(IN_PER_PORT)) u_in (
    .clk_i(clk_i), .rst_ni(rst_ni), .upd_i(rd_ok), .rdata_i(cmd_rdata_i),
    .shadow_o(hp_in_o), .chg_o(in_chg_o)
  );

  assign cmd_kind_o = kind;
  assign cmd_addr_o = exp_addr_i;
  assign cmd_reg_o  = (kind == CMD_READ) ? in_reg_i : out_reg_i;

  AST_NO_REQ_BEFORE_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_done_i |-> !cmd_req_o); // R1
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_req_o && !cmd_ack_i) |=>
      (cmd_req_o && $stable(cmd_kind_o) && $stable(cmd_wdata_o))); // R4
  AST_REQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_req_o && cmd_ack_i) |=> !cmd_req_o); // R4
  AST_RETRY_SAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_req_o && $past(cmd_req_o && cmd_ack_i && cmd_err_i, 2)) |->
      (cmd_wdata_o == $past(cmd_wdata_o, 2) && cmd_kind_o == $past(cmd_kind_o, 2))); // R5
  AST_CHG_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|in_chg_o) |-> $past(cmd_req_o && cmd_ack_i && !cmd_err_i && cmd_kind_o)); // R8
endmodule

// File: tb/hpx_bridge_tb_top.sv
module hpx_bridge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  // {expect_write, image}
  localparam logic [12:0] VEC [NV] = '{
    {1'b1, 12'h001}, {1'b1, 12'h800}, {1'b0, 12'h800},
    {1'b1, 12'hFFF}, {1'b1, 12'h000}, {1'b1, 12'h3C6}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_done = 1'b0;
  logic [11:0] hp_out = 12'h5A5;
  logic        int_n = 1'b0;
  logic        ack = 1'b0, err = 1'b0;
  logic [11:0] rdata = '0;
  logic        req, kind;
  logic [6:0]  addr;
  logic [7:0]  regoff;
  logic [11:0] wdata, hp_in;
  logic [2:0]  chg;
  int checks = 0, errors = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hpx_bridge dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_done_i(cfg_done),
    .exp_addr_i(7'h27), .out_reg_i(8'h02), .in_reg_i(8'h00),
    .hp_out_i(hp_out), .exp_int_ni(int_n),
    .cmd_req_o(req), .cmd_kind_o(kind), .cmd_addr_o(addr), .cmd_reg_o(regoff),
    .cmd_wdata_o(wdata), .cmd_ack_i(ack), .cmd_err_i(err), .cmd_rdata_i(rdata),
    .hp_in_o(hp_in), .in_chg_o(chg)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL R4 watchdog: actual hung, expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic exp_write(input string tag, input logic [11:0] img);
    chk({tag, " req"}, req, 1);
    chk({tag, " kind"}, kind, 0);
    chk({tag, " data"}, wdata, img);
    chk({tag, " addr"}, addr, 7'h27);
    chk({tag, " reg"}, regoff, 8'h02);
  endtask

  task automatic exp_read(input string tag);
    chk({tag, " req"}, req, 1);
    chk({tag, " kind"}, kind, 1);
    chk({tag, " reg"}, regoff, 8'h00);
  endtask

  task automatic do_ack(input logic e, input logic [11:0] rd);
    ack = 1'b1; err = e; rdata = rd;
    @(negedge clk);
    ack = 1'b0; err = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 req", req, 0);
    chk("R9 hp_in", hp_in, 0);
    chk("R9 chg", chg, 0);
    rst_n = 1'b1;
    // R1: outputs dirty and interrupt low, but not configured
    begin
      logic seen = 1'b0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        seen |= req;
      end
      int_n = 1'b1;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        seen |= req;
      end
      chk("R1 no req before cfg", seen, 0);
    end
    cfg_done = 1'b1;
    @(negedge clk);
    exp_write("R2 first image", 12'h5A5);
    do_ack(0, 0);
    chk("R4 drop after ack", req, 0);

    // vector walk: R2
    for (int v = 0; v < NV; v++) begin
      hp_out = VEC[v][11:0];
      @(negedge clk);
      if (VEC[v][12]) begin
        exp_write("R2 vector", VEC[v][11:0]);
        do_ack(0, 0);
        chk("R4 vector drop", req, 0);
      end else begin
        logic seen = 1'b0;
        for (int i = 0; i < 3; i++) begin
          seen |= req;
          @(negedge clk);
        end
        chk("R2 equal image no write", seen, 0);
      end
    end

    // R3 latency and R8 update
    int_n = 1'b0;
    @(negedge clk); chk("R3 sync stage1", req, 0);
    @(negedge clk); chk("R3 sync stage2", req, 0);
    @(negedge clk); exp_read("R3 read");
    int_n = 1'b1;
    repeat (2) @(negedge clk);
    do_ack(0, 12'h0F0);
    chk("R8 hp_in", hp_in, 12'h0F0);
    chk("R8 chg port1", chg, 3'b010);
    @(negedge clk);
    chk("R8 chg one cycle", chg, 0);
    chk("R3 no read when high", req, 0);

    // R3 level repeat
    int_n = 1'b0;
    repeat (3) @(negedge clk);
    exp_read("R3 level read1");
    do_ack(0, 12'h0F3);
    chk("R8 chg port0", chg, 3'b001);
    chk("R4 drop", req, 0);
    @(negedge clk);
    exp_read("R3 level repeat");
    int_n = 1'b1;
    repeat (2) @(negedge clk);
    do_ack(0, 12'h0F3);
    chk("R8 no change", chg, 0);

    // R10 failed read, R5 read retry
    int_n = 1'b0;
    repeat (3) @(negedge clk);
    exp_read("R10 read");
    int_n = 1'b1;
    repeat (2) @(negedge clk);
    do_ack(1, 12'hFFF);
    chk("R10 hp_in kept", hp_in, 12'h0F3);
    chk("R10 no strobe", chg, 0);
    chk("R5 gap", req, 0);
    @(negedge clk);
    exp_read("R5 read retry");
    do_ack(0, 12'h0F3);
    chk("R10 after retry no strobe", chg, 0);

    // R5 write retry keeps data, R6 follow-up
    hp_out = 12'h111;
    @(negedge clk);
    exp_write("R5 write", 12'h111);
    hp_out = 12'h222;
    @(negedge clk);
    do_ack(1, 0);
    chk("R5 gap w", req, 0);
    @(negedge clk);
    exp_write("R5 retry same", 12'h111);
    do_ack(0, 0);
    chk("R6 drop", req, 0);
    @(negedge clk);
    exp_write("R6 follow-up", 12'h222);
    do_ack(0, 0);

    // R6 coalescing
    hp_out = 12'h333;
    @(negedge clk);
    exp_write("R6 first", 12'h333);
    hp_out = 12'h444;
    @(negedge clk);
    hp_out = 12'h555;
    @(negedge clk);
    do_ack(0, 0);
    @(negedge clk);
    exp_write("R6 latest only", 12'h555);
    do_ack(0, 0);
    @(negedge clk);
    chk("R6 single follow-up", req, 0);

    // R7 queued read before follow-up write
    hp_out = 12'h666;
    @(negedge clk);
    exp_write("R7 write", 12'h666);
    int_n = 1'b0;
    hp_out = 12'h777;
    repeat (3) @(negedge clk);
    int_n = 1'b1;
    repeat (2) @(negedge clk);
    do_ack(0, 0);
    @(negedge clk);
    exp_read("R7 queued read first");
    do_ack(0, 12'h8F3);
    chk("R8 chg port2", chg, 3'b100);
    @(negedge clk);
    exp_write("R7 then write", 12'h777);
    do_ack(0, 0);
    begin
      logic seen = 1'b0;
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        seen |= req;
      end
      chk("R4 quiet at end", seen, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule